// File: doc/BRIEF.md
# Transmit Clock Loss Monitor

This block supervises one transmit channel's line clock. It uses the free-running master clock as its only time base. The raw transmit clock passes through a synchroniser into the master-clock domain. There its edges are found, and a saturating counter measures how long it has been since the last rising transition. When that gap grows past a fixed number of master-clock cycles, the block raises a loss status and a one-cycle interrupt pulse, which can be masked. The loss status drops again as soon as transmit-clock activity returns.

The same block decides which clock a maintenance pattern is timed from, and whether the line driver may stay on. The automatic all-ones and alarm-indication conditions always run from the master clock. Other internal patterns follow a select bit. A lost transmit clock turns the driver off, except in two cases: the channel is in remote loopback, or its pattern is timed from the master clock. An external master-clock-missing indication turns the driver off whatever else is set. The block also gives a one-cycle sample strobe on the chosen edge of the transmit clock, rising or falling.

Top module: `txclk_loss_mon`

## Requirements
- R1: `loss_status` rises exactly SYNC_STAGES+LOSS_LIMIT+2 master-clock edges after the last rising transition on `tx_clk_in`, which means more than LOSS_LIMIT (default 70) quiet cycles as seen in the master-clock domain. It stays low before that edge.
- R2: While the transmit clock stays absent, `loss_status` stays high indefinitely, because the timeout counter saturates and never wraps.
- R3: `loss_irq` is high for exactly one cycle, in the same cycle that `loss_status` rises, provided `irq_mask` is 0. With `irq_mask` at 1 there is no pulse.
- R4: `loss_status` falls SYNC_STAGES+1 master-clock edges after the first rising transition on `tx_clk_in` that follows a loss.
- R5: `ref_is_mclk` (1 = master clock, 0 = transmit clock) is 1 whenever `auto_all_ones` or `ais_en` is 1, regardless of `pattern_ref_mclk`. Otherwise it equals `pattern_en & pattern_ref_mclk`. It is registered, so it follows its inputs one edge later.
- R6: While `loss_status` is 1, `drv_enable` is 0 unless `remote_loopback` is 1 or `ref_is_mclk` is 1. With no loss, `drv_enable` is 1. The output is registered from the loss flag and the mode inputs.
- R7: `mclk_missing` = 1 forces `drv_enable` to 0 one edge later, over every other input.
- R8: `tx_sample_stb` is a one-cycle pulse SYNC_STAGES+1 master-clock edges after a rising `tx_clk_in` transition when `edge_sel_fall` = 0, and after a falling transition when `edge_sel_fall` = 1.
- R9: After synchronous reset, `loss_status`, `loss_irq`, `ref_is_mclk` and `tx_sample_stb` are 0 and `drv_enable` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Free-running master clock, the time base for the whole block |
| rst | input | 1 | Synchronous active-high reset |
| tx_clk_in | input | 1 | Raw transmit clock, asynchronous to mclk |
| edge_sel_fall | input | 1 | 0: strobe on rising transmit-clock edge, 1: on falling edge |
| irq_mask | input | 1 | 1 suppresses the loss interrupt pulse |
| remote_loopback | input | 1 | Channel is in remote loopback |
| pattern_en | input | 1 | An internal maintenance pattern is being sent |
| pattern_ref_mclk | input | 1 | Pattern clock select: 1 master clock, 0 transmit clock |
| auto_all_ones | input | 1 | Automatic all-ones condition active |
| ais_en | input | 1 | Alarm indication signal condition active |
| mclk_missing | input | 1 | Master clock absent, from an external detector |
| loss_status | output | 1 | Transmit clock loss flag |
| loss_irq | output | 1 | One-cycle loss interrupt pulse |
| ref_is_mclk | output | 1 | Pattern reference is the master clock |
| drv_enable | output | 1 | Line driver enable, 0 means high impedance |
| tx_sample_stb | output | 1 | Transmit data sample strobe on the chosen edge |

## Verification
The bench builds the block with its default LOSS_LIMIT of 70 and a two-stage synchroniser. It drives a transmit clock with a period of eight master-clock cycles. Because of this the exact rise and fall edges of the loss flag, the strobe offsets for both edge choices, and the saturation over several hundred quiet cycles all stay short enough to check cycle by cycle. Random mode words are applied while the clock is in a known state, either running or lost. This brings every combination of loopback, pattern select, forced-master-clock and master-clock-missing within reach of the driver-enable and reference checks.

// File: rtl/txclk_mon_pkg.sv
package txclk_mon_pkg;

  typedef enum logic {
    REF_TXCLK = 1'b0,
    REF_MCLK  = 1'b1
  } ref_src_e;

  typedef struct packed {
    logic remote_lb;
    logic pattern_on;
    logic patt_ref_mclk;
    logic auto_ones;
    logic ais_on;
  } tx_mode_t;

endpackage

// File: rtl/txclk_sync_edge.sv
module txclk_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise,
  output logic fall
);

  // flops 0..STAGES-1 form the synchroniser, flop STAGES holds the previous value
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= 1'b0;
    else     chain[0] <= async_in;
  end

  for (genvar i = 1; i <= STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[i] <= 1'b0;
      else     chain[i] <= chain[i-1];
    end
  end

  assign rise =  chain[STAGES-1] & ~chain[STAGES];
  assign fall = ~chain[STAGES-1] &  chain[STAGES];

endmodule

// File: rtl/txclk_loss_timer.sv
module txclk_loss_timer #(
  parameter int LIMIT = 70,
  parameter int CNT_W = $clog2(LIMIT + 2)
) (
  input  logic clk,
  input  logic rst,
  input  logic activity,
  input  logic irq_mask,
  output logic loss,
  output logic irq
);

  localparam logic [CNT_W-1:0] SAT   = CNT_W'(LIMIT + 1);
  localparam logic [CNT_W-1:0] LIM_C = CNT_W'(LIMIT);

  logic [CNT_W-1:0] quiet_cnt;
  logic             loss_nxt;

  always_ff @(posedge clk) begin
    if (rst)                  quiet_cnt <= '0;
    else if (activity)        quiet_cnt <= '0;
    else if (quiet_cnt != SAT) quiet_cnt <= quiet_cnt + 1'b1;
  end

  assign loss_nxt = !activity && (quiet_cnt >= LIM_C);

  always_ff @(posedge clk) begin
    if (rst) begin
      loss <= 1'b0;
      irq  <= 1'b0;
    end else begin
      loss <= loss_nxt;
      irq  <= loss_nxt & ~loss & ~irq_mask;
    end
  end

endmodule

// File: rtl/txclk_drive_ctrl.sv
module txclk_drive_ctrl
  import txclk_mon_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  tx_mode_t mode,
  input  logic     loss,
  input  logic     mclk_missing,
  input  logic     rise,
  input  logic     fall,
  input  logic     edge_sel_fall,
  output logic     ref_mclk,
  output logic     drv_en,
  output logic     strobe
);

  ref_src_e ref_sel;
  logic     force_mclk;
  logic     keep_driving;
  logic     drv_nxt;

  always_comb begin
    force_mclk = mode.auto_ones | mode.ais_on;
    if (force_mclk)
      ref_sel = REF_MCLK;
    else if (mode.pattern_on && mode.patt_ref_mclk)
      ref_sel = REF_MCLK;
    else
      ref_sel = REF_TXCLK;
    keep_driving = mode.remote_lb | (ref_sel == REF_MCLK);
    // missing master clock outranks every other term
    if (mclk_missing) drv_nxt = 1'b0;
    else if (loss)    drv_nxt = keep_driving;
    else              drv_nxt = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_mclk <= 1'b0;
      drv_en   <= 1'b1;
      strobe   <= 1'b0;
    end else begin
      ref_mclk <= (ref_sel == REF_MCLK);
      drv_en   <= drv_nxt;
      strobe   <= edge_sel_fall ? fall : rise;
    end
  end

endmodule

// File: rtl/txclk_loss_mon.sv
module txclk_loss_mon
  import txclk_mon_pkg::*;
#(
  parameter int LOSS_LIMIT  = 70,
  parameter int SYNC_STAGES = 2
) (
  input  logic mclk,
  input  logic rst,
  input  logic tx_clk_in,
  input  logic edge_sel_fall,
  input  logic irq_mask,
  input  logic remote_loopback,
  input  logic pattern_en,
  input  logic pattern_ref_mclk,
  input  logic auto_all_ones,
  input  logic ais_en,
  input  logic mclk_missing,
  output logic loss_status,
  output logic loss_irq,
  output logic ref_is_mclk,
  output logic drv_enable,
  output logic tx_sample_stb
);

  localparam int CNT_W = $clog2(LOSS_LIMIT + 2);

  logic     tx_rise;
  logic     tx_fall;
  tx_mode_t mode;

  assign mode = '{remote_lb:     remote_loopback,
                  pattern_on:    pattern_en,
                  patt_ref_mclk: pattern_ref_mclk,
                  auto_ones:     auto_all_ones,
                  ais_on:        ais_en};

  txclk_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (mclk),
    .rst      (rst),
    .async_in (tx_clk_in),
    .rise     (tx_rise),
    .fall     (tx_fall)
  );

  txclk_loss_timer #(.LIMIT(LOSS_LIMIT), .CNT_W(CNT_W)) u_timer (
    .clk      (mclk),
    .rst      (rst),
    .activity (tx_rise),
    .irq_mask (irq_mask),
    .loss     (loss_status),
    .irq      (loss_irq)
  );

  txclk_drive_ctrl u_ctrl (
    .clk           (mclk),
    .rst           (rst),
    .mode          (mode),
    .loss          (loss_status),
    .mclk_missing  (mclk_missing),
    .rise          (tx_rise),
    .fall          (tx_fall),
    .edge_sel_fall (edge_sel_fall),
    .ref_mclk      (ref_is_mclk),
    .drv_en        (drv_enable),
    .strobe        (tx_sample_stb)
  );

endmodule

// File: rtl/txclk_loss_mon_chk.sv
module txclk_loss_mon_chk (
  input logic mclk,
  input logic rst,
  input logic irq_mask,
  input logic remote_loopback,
  input logic pattern_en,
  input logic pattern_ref_mclk,
  input logic auto_all_ones,
  input logic ais_en,
  input logic mclk_missing,
  input logic loss_status,
  input logic loss_irq,
  input logic ref_is_mclk,
  input logic drv_enable
);

  assert_irq_pulse_R3: assert property (@(posedge mclk) disable iff (rst)
    loss_irq |=> !loss_irq);

  assert_irq_on_loss_rise_R3: assert property (@(posedge mclk) disable iff (rst)
    loss_irq |-> (loss_status && !$past(loss_status) && !$past(irq_mask)));

  assert_forced_ref_R5: assert property (@(posedge mclk) disable iff (rst)
    (!$past(rst) && ($past(auto_all_ones) || $past(ais_en))) |-> ref_is_mclk);

  assert_loss_tristate_R6: assert property (@(posedge mclk) disable iff (rst)
    (!$past(rst) && $past(loss_status) && !$past(remote_loopback)
     && !$past(auto_all_ones) && !$past(ais_en)
     && !($past(pattern_en) && $past(pattern_ref_mclk))) |-> !drv_enable);

  assert_mclk_missing_R7: assert property (@(posedge mclk) disable iff (rst)
    (!$past(rst) && $past(mclk_missing)) |-> !drv_enable);

endmodule

bind txclk_loss_mon txclk_loss_mon_chk u_chk (.*);

// File: tb/txclk_loss_mon_tb.sv
module txclk_loss_mon_tb;

  localparam int LIMIT  = 70;
  localparam int STAGES = 2;
  localparam int HALF   = 4;

  logic mclk = 1'b0, rst = 1'b1, txclk = 1'b0;
  logic edge_sel_fall = 1'b0, irq_mask = 1'b0, remote_loopback = 1'b0;
  logic pattern_en = 1'b0, pattern_ref_mclk = 1'b0, auto_all_ones = 1'b0;
  logic ais_en = 1'b0, mclk_missing = 1'b0;
  logic loss_status, loss_irq, ref_is_mclk, drv_enable, tx_sample_stb;

  int checks = 0, failures = 0;
  int cyc = 0;
  bit tx_run = 1'b0;
  int ph = 0, last_rise = 0, last_fall = 0;

  always #4 mclk = ~mclk;
  always @(posedge mclk) cyc <= cyc + 1;

  always @(negedge mclk) begin
    if (tx_run) begin
      if (ph == HALF - 1) begin
        ph    <= 0;
        txclk <= ~txclk;
        if (!txclk) last_rise <= cyc;
        else        last_fall <= cyc;
      end else ph <= ph + 1;
    end
  end

  txclk_loss_mon #(.LOSS_LIMIT(LIMIT), .SYNC_STAGES(STAGES)) u_dut (
    .mclk, .rst, .tx_clk_in(txclk), .edge_sel_fall, .irq_mask,
    .remote_loopback, .pattern_en, .pattern_ref_mclk, .auto_all_ones,
    .ais_en, .mclk_missing, .loss_status, .loss_irq, .ref_is_mclk,
    .drv_enable, .tx_sample_stb
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic smp();
    @(negedge mclk);
    #1;
  endtask

  task automatic wait_until(input int target);
    while (cyc < target) smp();
  endtask

  function automatic bit f_ref(bit pe, bit prm, bit ao, bit ai);
    return ao | ai | (pe & prm);
  endfunction

  function automatic bit f_drv(bit miss, bit loss, bit rl, bit pe, bit prm, bit ao, bit ai);
    if (miss) return 1'b0;
    if (!loss) return 1'b1;
    return rl | f_ref(pe, prm, ao, ai);
  endfunction

  task automatic stop_clock();
    @(posedge mclk);
    tx_run = 1'b0;
    smp();
  endtask

  task automatic start_clock();
    @(posedge mclk);
    tx_run = 1'b1;
    smp();
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int l_rise, target, n_irq, n_stb;
    void'($urandom(32'd20240611));
    tx_run = 1'b1;
    repeat (6) smp();
    rst = 1'b0;
    smp();
    // R9 reset values
    chk(loss_status == 0, "R9 loss", loss_status, 0);
    chk(loss_irq == 0, "R9 irq", loss_irq, 0);
    chk(ref_is_mclk == 0, "R9 ref", ref_is_mclk, 0);
    chk(drv_enable == 1, "R9 drv", drv_enable, 1);
    repeat (100) smp();
    chk(loss_status == 0, "R1 no loss while running", loss_status, 0);

    // R8 strobe on rising edge, then falling edge
    for (int sel = 0; sel < 2; sel++) begin
      edge_sel_fall = sel[0];
      repeat (10) smp();
      n_stb = 0;
      for (int k = 0; k < 64; k++) begin
        smp();
        if (tx_sample_stb) begin
          n_stb++;
          chk((cyc - (sel ? last_fall : last_rise)) == STAGES + 1, "R8 strobe offset",
              cyc - (sel ? last_fall : last_rise), STAGES + 1);
        end
      end
      chk(n_stb == 8, "R8 strobe count", n_stb, 8);
    end
    edge_sel_fall = 1'b0;

    // R1/R3/R2 loss detection with interrupt unmasked
    stop_clock();
    l_rise = last_rise;
    target = l_rise + STAGES + LIMIT + 2;
    wait_until(target - 1);
    chk(loss_status == 0, "R1 not before limit", loss_status, 0);
    smp();
    chk(loss_status == 1, "R1 loss at limit", loss_status, 1);
    chk(loss_irq == 1, "R3 irq with loss", loss_irq, 1);
    smp();
    chk(loss_irq == 0, "R3 irq single cycle", loss_irq, 0);
    chk(drv_enable == 0, "R6 driver off on loss", drv_enable, 0);
    n_irq = 0;
    for (int k = 0; k < 400; k++) begin
      smp();
      if (loss_irq) n_irq++;
      if (!loss_status) chk(1'b0, "R2 loss held", 0, 1);
    end
    chk(loss_status == 1, "R2 loss saturates", loss_status, 1);
    chk(n_irq == 0, "R3 no repeat irq", n_irq, 0);
    chk(tx_sample_stb == 0, "R8 no strobe when stopped", tx_sample_stb, 0);

    // R4 recovery
    start_clock();
    while (last_rise == l_rise) smp();
    l_rise = last_rise;
    wait_until(l_rise + STAGES);
    chk(loss_status == 1, "R4 held until sync", loss_status, 1);
    smp();
    chk(loss_status == 0, "R4 cleared", loss_status, 0);
    smp();
    chk(drv_enable == 1, "R6 driver back on", drv_enable, 1);

    // R3 masked interrupt
    irq_mask = 1'b1;
    stop_clock();
    n_irq = 0;
    for (int k = 0; k < LIMIT + 30; k++) begin
      smp();
      if (loss_irq) n_irq++;
    end
    chk(loss_status == 1, "R1 loss while masked", loss_status, 1);
    chk(n_irq == 0, "R3 masked irq", n_irq, 0);
    start_clock();
    repeat (30) smp();
    irq_mask = 1'b0;
    chk(loss_status == 0, "R4 cleared after masked loss", loss_status, 0);

    // R7 directed: missing master clock overrides loopback
    remote_loopback = 1'b1;
    mclk_missing = 1'b1;
    smp(); smp();
    chk(drv_enable == 0, "R7 mclk missing", drv_enable, 0);
    mclk_missing = 1'b0;
    remote_loopback = 1'b0;

    // R5/R6/R7 random mode words in known loss states
    for (int blk = 0; blk < 6; blk++) begin
      bit lost;
      lost = blk[0];
      if (lost) stop_clock(); else start_clock();
      repeat (LIMIT + 40) smp();
      chk(loss_status == lost, "R1 known state", loss_status, lost);
      for (int it = 0; it < 30; it++) begin
        bit [5:0] w;
        w = 6'($urandom);
        remote_loopback  = w[0];
        pattern_en       = w[1];
        pattern_ref_mclk = w[2];
        auto_all_ones    = w[3] & w[4];
        ais_en           = w[5] & ~w[4];
        mclk_missing     = (($urandom % 4) == 0);
        smp(); smp();
        chk(ref_is_mclk == f_ref(pattern_en, pattern_ref_mclk, auto_all_ones, ais_en),
            "R5 reference select", ref_is_mclk,
            f_ref(pattern_en, pattern_ref_mclk, auto_all_ones, ais_en));
        chk(drv_enable == f_drv(mclk_missing, lost, remote_loopback, pattern_en,
                                pattern_ref_mclk, auto_all_ones, ais_en),
            mclk_missing ? "R7 driver enable" : "R6 driver enable", drv_enable,
            f_drv(mclk_missing, lost, remote_loopback, pattern_en,
                  pattern_ref_mclk, auto_all_ones, ais_en));
      end
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule